// File: doc/BRIEF.md
# Shift-Add Constant Multiplier (x * 1812433253)

This block multiplies an operand by the fixed constant 1812433253 and returns the low word of the product. It contains no general multiplier. The product is assembled from hard-wired left shifts and a small graph of seven adders and subtractors. Every intermediate term is held modulo 2^W, so bits shifted past the top of the word are dropped and differences wrap.

A valid strobe travels with the operand. The parameter `STAGES` picks one of three variants:
- 0: the path is purely combinational.
- 1: a single register sits on the result.
- 2: one register cuts the adder graph between its second and third adder levels, and a second register sits on the result.

The result has a fixed latency of `STAGES` clock edges. The block fits inside hashing or seeding datapaths that need this multiply at one result per cycle with low logic cost.

Top module: `cmul_shiftadd`

## Requirements
- R1: For every variant, a valid output carries (operand * 1812433253) mod 2^W for the operand that entered with the matching valid. With the default W=32 this is the low 32 bits of the product.
- R2: The result is the same bit pattern for signed and unsigned readings of the operand. Operand 0xFFFFFFFF gives 0x93F8769B, and operand 0x80000000 gives 0x80000000.
- R3: The datapath computes the intermediate terms 3x, 15x, 19x, 27x, 55311x and 2405x. It uses seven add/subtract operations in total, and all other scaling is done by constant shifts.
- R4: Operand 0 gives 0, and operand 1 gives 0x6C078965.
- R5: When STAGES is 1 or 2, `out_vld` equals `in_vld` as it was that many rising edges earlier. A cycle with `in_vld` low produces a cycle with `out_vld` low.
- R6: A rising edge with `rst` high clears every valid bit in the pipeline, including a valid that is entering in that cycle. `out_vld` reads 0 after that edge.
- R7: When STAGES is 0, `out_vld` follows `in_vld` and `out_res` follows `in_op` in the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active (unused when STAGES=0) |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_vld | input | 1 | Operand valid |
| in_op | input | W | Operand |
| out_vld | output | 1 | Result valid |
| out_res | output | W | Low W bits of operand * 1812433253 |

## Verification
The hardest case to reach from the ports is a reset that lands while valid operands fill both register stages. In that case each stage must drop its valid bit, even though the data registers keep stale contents. The bench drives a dense run of valid operands into all three variants side by side and raises reset in the middle of the run. It then checks that no stale result is reported valid and that the stream resumes with the correct latency. The arithmetic is covered by walking-one, walking-zero and byte-sweep patterns, the sign-boundary values, and several thousand random operands with random gaps in the valid strobe.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
   // fixed multiplier constant, hex 0x6C078965
   localparam logic [31:0] MUL_K = 32'd1812433253;

   // shift amounts of the adder graph
   localparam int SH_X2   = 1;   // 2x, feeds 3x
   localparam int SH_X24  = 3;   // 3x -> 24x, feeds 27x
   localparam int SH_X16  = 4;   // 16x
   localparam int SH_HI   = 11;  // 27x -> 55296x
   localparam int SH_MID  = 7;   // 19x -> 2432x
   localparam int SH_TOP  = 15;  // 55311x -> top part

   localparam int MAX_STAGES = 2;

   function automatic bit stages_ok(input int s);
      return (s >= 0) && (s <= MAX_STAGES);
   endfunction
endpackage

// File: rtl/cmul_front.sv
// Adder levels 1 and 2: four operations, producing 15x, 19x and 27x.
module cmul_front
   import cmul_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] op,
   output logic [W-1:0] t15,
   output logic [W-1:0] t19,
   output logic [W-1:0] t27
);
   logic [W-1:0] t3;
   logic [W-1:0] t16;

   always_comb begin
      t16 = op << SH_X16;                 // wired shift
      t3  = (op << SH_X2) + op;           // op 1
      t15 = t16 - op;                     // op 2
      t27 = (t3 << SH_X24) + t3;          // op 3
      t19 = t16 + t3;                     // op 4
   end

   // R3: intermediate terms hold their multiples of the operand
   always_comb begin
      p_t3_r3:  assert (t3  == op * W'(3));
      p_t15_r3: assert (t15 == op * W'(15));
      p_t19_r3: assert (t19 == op * W'(19));
      p_t27_r3: assert (t27 == op * W'(27));
   end
endmodule

// File: rtl/cmul_back.sv
// Adder levels 3 and 4: three operations, producing the final product.
module cmul_back
   import cmul_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] t15,
   input  logic [W-1:0] t19,
   input  logic [W-1:0] t27,
   output logic [W-1:0] prod
);
   logic [W-1:0] t55311;
   logic [W-1:0] t2405;

   always_comb begin
      t55311 = (t27 << SH_HI) + t15;      // op 5
      t2405  = (t19 << SH_MID) - t27;     // op 6
      prod   = (t55311 << SH_TOP) + t2405; // op 7
   end

   // R3: level-3 terms relate to the level-2 terms feeding them
   always_comb begin
      p_t55311_r3: assert (t55311 * W'(27) == t27 * W'(55311));
      p_t2405_r3:  assert (t2405 * W'(27) == t27 * W'(2405));
   end
endmodule

// File: rtl/cmul_pipe_reg.sv
// One pipeline stage: reset valid bit, data captured only on valid.
module cmul_pipe_reg #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          i_vld,
   input  logic [DW-1:0] i_dat,
   output logic          o_vld,
   output logic [DW-1:0] o_dat
);
   always_ff @(posedge clk) begin
      if (rst) o_vld <= 1'b0;
      else     o_vld <= i_vld;
   end

   always_ff @(posedge clk) begin
      if (i_vld) o_dat <= i_dat;
   end

   // R5: valid advances one edge per stage outside reset
   p_vld_follow_r5: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (o_vld == $past(i_vld)));

   // R5: data holds when no valid entered
   p_dat_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !$past(i_vld) |-> $stable(o_dat));
endmodule

// File: rtl/cmul_shiftadd.sv
module cmul_shiftadd
   import cmul_pkg::*;
#(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_vld,
   input  logic [W-1:0] in_op,
   output logic         out_vld,
   output logic [W-1:0] out_res
);
   localparam logic [W-1:0] K_W   = W'(MUL_K);
   localparam int           MID_W = 3 * W;

   if (!stages_ok(STAGES)) begin : g_bad_stages
      $error("cmul_shiftadd: STAGES must be 0, 1 or 2");
   end
   if (W < 1) begin : g_bad_width
      $error("cmul_shiftadd: W must be positive");
   end

   if (STAGES == 0) begin : g_comb
      logic [W-1:0] f15, f19, f27;
      cmul_front #(.W(W)) u_front (.op(in_op), .t15(f15), .t19(f19), .t27(f27));
      cmul_back  #(.W(W)) u_back  (.t15(f15), .t19(f19), .t27(f27), .prod(out_res));
      assign out_vld = in_vld;

      always_comb begin
         p_comb_vld_r7: assert (out_vld == in_vld);
         if (in_vld) begin
            p_comb_res_r1: assert (out_res == in_op * K_W);
         end
      end
   end else if (STAGES == 1) begin : g_outreg
      logic [W-1:0] f15, f19, f27, prod;
      cmul_front #(.W(W)) u_front (.op(in_op), .t15(f15), .t19(f19), .t27(f27));
      cmul_back  #(.W(W)) u_back  (.t15(f15), .t19(f19), .t27(f27), .prod(prod));
      cmul_pipe_reg #(.DW(W)) u_oreg (
         .clk(clk), .rst(rst), .i_vld(in_vld), .i_dat(prod),
         .o_vld(out_vld), .o_dat(out_res));

      p_res_s1_r1: assert property (@(posedge clk) disable iff (rst)
         out_vld |-> (out_res == $past(in_op) * K_W));
   end else begin : g_split
      logic [W-1:0]     f15, f19, f27, prod;
      logic [MID_W-1:0] mid_d, mid_q;
      logic             mid_vld;
      cmul_front #(.W(W)) u_front (.op(in_op), .t15(f15), .t19(f19), .t27(f27));
      assign mid_d = {f15, f19, f27};
      cmul_pipe_reg #(.DW(MID_W)) u_mreg (
         .clk(clk), .rst(rst), .i_vld(in_vld), .i_dat(mid_d),
         .o_vld(mid_vld), .o_dat(mid_q));
      cmul_back #(.W(W)) u_back (
         .t15(mid_q[3*W-1:2*W]), .t19(mid_q[2*W-1:W]), .t27(mid_q[W-1:0]),
         .prod(prod));
      cmul_pipe_reg #(.DW(W)) u_oreg (
         .clk(clk), .rst(rst), .i_vld(mid_vld), .i_dat(prod),
         .o_vld(out_vld), .o_dat(out_res));

      p_res_s2_r1: assert property (@(posedge clk) disable iff (rst)
         out_vld |-> (out_res == $past(in_op, 2) * K_W));
   end

   if (STAGES > 0) begin : g_rst_chk
      logic rst_q;
      always_ff @(posedge clk) begin
         rst_q <= rst;
         // R6: output valid is low in the cycle after a reset edge
         if (rst_q) begin
            p_rst_clear_r6: assert (!out_vld);
         end
      end
   end
endmodule

// File: tb/cmul_shiftadd_bench.sv
module cmul_shiftadd_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] K = 32'd1812433253;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_vld = 1'b0;
   logic [31:0] in_op = '0;
   logic v0, v1, v2;
   logic [31:0] r0, r1, r2;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench-side delay line of applied inputs
   logic h1_vld = 1'b0, h2_vld = 1'b0;
   logic [31:0] h1_op = '0, h2_op = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmul_shiftadd #(.W(32), .STAGES(0)) u_cmul_shiftadd_s0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .out_vld(v0), .out_res(r0));
   cmul_shiftadd #(.W(32), .STAGES(1)) u_cmul_shiftadd_s1 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .out_vld(v1), .out_res(r1));
   cmul_shiftadd #(.W(32), .STAGES(2)) u_cmul_shiftadd (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .out_vld(v2), .out_res(r2));

   function automatic logic [31:0] ref_mul(input logic [31:0] a);
      logic [63:0] p;
      p = {32'd0, a} * {32'd0, K};
      return p[31:0];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // sample pipelined outputs, then drive new inputs and check combinational variant
   task automatic step(input logic v, input logic [31:0] op, input logic r);
      @(negedge clk);
      chk(v1 == h1_vld, "R5/R6 stage1 valid", {31'd0, v1}, {31'd0, h1_vld});
      if (h1_vld) chk(r1 == ref_mul(h1_op), "R1 stage1 result", r1, ref_mul(h1_op));
      chk(v2 == h2_vld, "R5/R6 stage2 valid", {31'd0, v2}, {31'd0, h2_vld});
      if (h2_vld) chk(r2 == ref_mul(h2_op), "R1 stage2 result", r2, ref_mul(h2_op));
      in_vld = v;
      in_op  = op;
      rst    = r;
      #1;
      chk(v0 == v, "R7 comb valid", {31'd0, v0}, {31'd0, v});
      if (v) chk(r0 == ref_mul(op), "R7/R1 comb result", r0, ref_mul(op));
      h2_vld = r ? 1'b0 : h1_vld;
      h2_op  = h1_op;
      h1_vld = r ? 1'b0 : v;
      h1_op  = op;
   endtask

   task automatic directed(input logic [31:0] op, input logic [31:0] exp, input string tag);
      step(1'b1, op, 1'b0);
      chk(r0 == exp, tag, r0, exp);
   endtask

   initial begin
      // reset state (R6)
      for (int i = 0; i < 3; i++) step(1'b1, 32'h1234_5678, 1'b1);
      step(1'b0, '0, 1'b0);
      chk(!v1 && !v2, "R6 reset state", {30'd0, v1, v2}, 32'd0);

      // corner operands
      directed(32'h0000_0000, 32'h0000_0000, "R4 zero");
      directed(32'h0000_0001, 32'h6C07_8965, "R4 one");
      directed(32'hFFFF_FFFF, 32'h93F8_769B, "R2 minus one");
      directed(32'h8000_0000, 32'h8000_0000, "R2 sign bit");
      directed(32'h0000_0003, 32'h4416_9C2F, "R3 three");
      step(1'b0, '0, 1'b0);
      step(1'b0, '0, 1'b0);

      // walking ones and zeros (R1, R3)
      for (int b = 0; b < 32; b++) step(1'b1, 32'd1 << b, 1'b0);
      for (int b = 0; b < 32; b++) step(1'b1, ~(32'd1 << b), 1'b0);
      // byte sweeps in each byte lane
      for (int lane = 0; lane < 4; lane++)
         for (int v = 0; v < 256; v++) step(1'b1, 32'(v) << (8 * lane), 1'b0);

      // reset in the middle of a dense valid stream (R6)
      for (int i = 0; i < 4; i++) step(1'b1, $urandom, 1'b0);
      step(1'b1, 32'hDEAD_BEEF, 1'b1);
      step(1'b1, 32'h0BAD_F00D, 1'b0);
      step(1'b1, 32'h1357_9BDF, 1'b0);
      step(1'b0, '0, 1'b0);

      // valid gaps only (R5: no valid out of an idle input)
      for (int i = 0; i < 4; i++) step(1'b0, $urandom, 1'b0);

      // random operands with random valid gaps and occasional reset
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] dice;
         dice = 8'($urandom);
         step(dice[1:0] != 2'b00, $urandom, dice == 8'hA5);
      end
      step(1'b0, '0, 1'b0);
      step(1'b0, '0, 1'b0);
      step(1'b0, '0, 1'b0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule